// File: doc/BRIEF.md
# Fixed-Segment Address Translator

This block turns a 32-bit virtual address into a physical address for a processor that has no TLB. It decodes the segment from the top three address bits and applies a fixed rule for each segment. It also reports whether the access may be cached and whether it breaks the privilege rules. The block takes a privilege flag, which says whether the access is kernel or user. It also takes an error-level override flag. While the override is set, the low 2 GB user segment becomes an identity-mapped, uncached window.

The translation logic is combinational and feeds one register stage. A request accepted in one cycle therefore appears with its valid flag in the next cycle. The block only flags an address error. Taking the exception is left to the pipeline that consumes the result.

Top module: `fmx_xlat`

## Requirements
- R1: The segment is chosen by virtual address bits [31:29]: 0xx is the user segment (0x0000_0000 to 0x7FFF_FFFF), 100 is kernel-cached (from 0x8000_0000), 101 is kernel-uncached (from 0xA000_0000), 110 is kernel-mapped-low (from 0xC000_0000) and 111 is kernel-mapped-high (from 0xE000_0000).
- R2: In the kernel-cached and kernel-uncached segments, the physical address is the virtual address with bits [31:29] forced to zero. The kernel-cached segment reports cached=1 and the kernel-uncached segment reports cached=0.
- R3: In the two segments at and above 0xC000_0000, the physical address equals the virtual address and cached=1.
- R4: In the user segment with the error-level flag low, the physical address is the virtual address plus 0x4000_0000 (modulo 2^32) and cached=1.
- R5: In the user segment with the error-level flag high, the physical address equals the virtual address and cached=0.
- R6: No address whose bit 31 is set ever yields a physical address in the window from 0x8000_0000 to 0xBFFF_FFFF.
- R7: A user-mode access with virtual bit 31 set reports fault=1. In that case the physical address and cached outputs are not checked. No other access reports a fault.
- R8: A request with in_valid high is reported one clock later with out_valid high. A cycle with in_valid low gives out_valid low in the next cycle and leaves out_paddr, out_cached and out_fault unchanged.
- R9: While reset is held, and in the first cycle after it, out_valid, out_paddr, out_cached and out_fault are all zero.
- R10: The error-level flag has no effect on addresses with bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_vaddr | input | 32 | Virtual address |
| in_kernel | input | 1 | 1 = kernel privilege, 0 = user |
| in_erl | input | 1 | Error-level override flag |
| out_valid | output | 1 | Result present this cycle |
| out_paddr | output | 32 | Physical address |
| out_cached | output | 1 | 1 = access may be cached |
| out_fault | output | 1 | Address error detected |

## Verification
All four results are due exactly one rising edge after the request. They are the physical address, the cached attribute, the fault flag and the valid flag. The bench drives each request on a falling edge and samples the outputs on the next falling edge, so exactly one rising edge lies between drive and check. It sweeps the first, a middle and the last address of every 512 MB slice, under both privilege levels and both override values. Idle cycles are checked on the following falling edge for a low valid flag and unchanged data.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
   localparam int FMX_AW = 32;

   typedef enum logic [2:0] {
      SEG_USER = 3'd0,
      SEG_KC   = 3'd1,
      SEG_KU   = 3'd2,
      SEG_KML  = 3'd3,
      SEG_KMH  = 3'd4
   } seg_e;

   typedef struct packed {
      logic cached;
      logic fault;
   } attr_t;
endpackage

// File: rtl/fmx_seg_decode.sv
module fmx_seg_decode
   import fmx_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] vaddr,
   output seg_e              seg
);
   localparam int TOP = ADDR_W - 1;

   if (ADDR_W != FMX_AW) begin : g_bad_width
      $error("fmx_seg_decode: ADDR_W must be 32");
   end

   always_comb begin
      seg = SEG_USER;
      unique casez (vaddr[TOP -: 3])
         3'b0??: seg = SEG_USER;
         3'b100: seg = SEG_KC;
         3'b101: seg = SEG_KU;
         3'b110: seg = SEG_KML;
         3'b111: seg = SEG_KMH;
         default: seg = SEG_USER;
      endcase
   end
endmodule

// File: rtl/fmx_map.sv
module fmx_map
   import fmx_pkg::*;
#(
   parameter int              ADDR_W      = 32,
   parameter logic [31:0]     USER_OFFSET = 32'h4000_0000
) (
   input  seg_e              seg,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              kernel,
   input  logic              erl,
   output logic [ADDR_W-1:0] paddr,
   output attr_t             attr
);
   localparam int TOP    = ADDR_W - 1;
   localparam int FOLD_W = ADDR_W - 3;

   if (ADDR_W != FMX_AW) begin : g_bad_width
      $error("fmx_map: ADDR_W must be 32");
   end
   if (USER_OFFSET[28:0] != '0) begin : g_bad_offset
      $error("fmx_map: USER_OFFSET must be 512 MB aligned");
   end

   logic [ADDR_W-1:0] folded;
   logic [ADDR_W-1:0] shifted;

   assign folded  = {3'b000, vaddr[FOLD_W-1:0]};
   assign shifted = vaddr + USER_OFFSET;

   always_comb begin
      paddr       = vaddr;
      attr.cached = 1'b1;
      attr.fault  = !kernel && vaddr[TOP];
      case (seg)
         SEG_USER: begin
            if (erl) begin
               paddr       = vaddr;
               attr.cached = 1'b0;
            end else begin
               paddr       = shifted;
               attr.cached = 1'b1;
            end
         end
         SEG_KC: begin
            paddr       = folded;
            attr.cached = 1'b1;
         end
         SEG_KU: begin
            paddr       = folded;
            attr.cached = 1'b0;
         end
         SEG_KML, SEG_KMH: begin
            paddr       = vaddr;
            attr.cached = 1'b1;
         end
         default: begin
            paddr       = vaddr;
            attr.cached = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/fmx_out_stage.sv
module fmx_out_stage
   import fmx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [ADDR_W-1:0] d_paddr,
   input  attr_t             d_attr,
   output logic              q_valid,
   output logic [ADDR_W-1:0] q_paddr,
   output attr_t             q_attr
);
   always_ff @(posedge clk) begin
      if (!rst_n) q_valid <= 1'b0;
      else        q_valid <= d_valid;
   end

   if (RESET_DATA) begin : g_rst_data
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_paddr <= '0;
            q_attr  <= '0;
         end else if (d_valid) begin
            q_paddr <= d_paddr;
            q_attr  <= d_attr;
         end
      end
   end else begin : g_free_data
      always_ff @(posedge clk) begin
         if (d_valid) begin
            q_paddr <= d_paddr;
            q_attr  <= d_attr;
         end
      end
   end
endmodule

// File: rtl/fmx_xlat.sv
module fmx_xlat
   import fmx_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter logic [31:0] USER_OFFSET = 32'h4000_0000,
   parameter bit          RESET_DATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_vaddr,
   input  logic              in_kernel,
   input  logic              in_erl,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_paddr,
   output logic              out_cached,
   output logic              out_fault
);
   seg_e              seg;
   logic [ADDR_W-1:0] map_paddr;
   attr_t             map_attr;
   attr_t             reg_attr;

   fmx_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .vaddr (in_vaddr),
      .seg   (seg)
   );

   fmx_map #(.ADDR_W(ADDR_W), .USER_OFFSET(USER_OFFSET)) u_map (
      .seg    (seg),
      .vaddr  (in_vaddr),
      .kernel (in_kernel),
      .erl    (in_erl),
      .paddr  (map_paddr),
      .attr   (map_attr)
   );

   fmx_out_stage #(.ADDR_W(ADDR_W), .RESET_DATA(RESET_DATA)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d_paddr (map_paddr),
      .d_attr  (map_attr),
      .q_valid (out_valid),
      .q_paddr (out_paddr),
      .q_attr  (reg_attr)
   );

   assign out_cached = reg_attr.cached;
   assign out_fault  = reg_attr.fault;
endmodule

// File: rtl/fmx_xlat_chk.sv
module fmx_xlat_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] in_vaddr,
   input logic              in_kernel,
   input logic              in_erl,
   input logic              out_valid,
   input logic [ADDR_W-1:0] out_paddr,
   input logic              out_cached,
   input logic              out_fault
);
   localparam int TOP = ADDR_W - 1;

   // R8: valid travels one cycle behind the request
   p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_paddr));

   // R6: high addresses never land in the reserved physical window
   p_no_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_vaddr[TOP]) |=> (out_paddr[TOP -: 2] != 2'b10));

   // R5: override makes the user segment identity and uncached
   p_erl_ident_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_erl && !in_vaddr[TOP]) |=>
         (out_paddr == $past(in_vaddr)) && !out_cached);

   // R3: upper kernel segments are identity mapped
   p_upper_ident_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kernel && in_vaddr[TOP -: 2] == 2'b11) |=>
         (out_paddr == $past(in_vaddr)) && out_cached);

   // R7: fault only for user access to high addresses
   p_user_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_kernel && in_vaddr[TOP]) |=> out_fault);
   p_no_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_kernel || !in_vaddr[TOP])) |=> !out_fault);
endmodule

bind fmx_xlat fmx_xlat_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_vaddr   (in_vaddr),
   .in_kernel  (in_kernel),
   .in_erl     (in_erl),
   .out_valid  (out_valid),
   .out_paddr  (out_paddr),
   .out_cached (out_cached),
   .out_fault  (out_fault)
);

// File: tb/fmx_xlat_tb_top.sv
`timescale 1ns/1ps
module fmx_xlat_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_vaddr = '0;
   logic        in_kernel = 1'b0;
   logic        in_erl = 1'b0;
   logic        out_valid;
   logic [31:0] out_paddr;
   logic        out_cached;
   logic        out_fault;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fmx_xlat dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
      .in_kernel(in_kernel), .in_erl(in_erl), .out_valid(out_valid),
      .out_paddr(out_paddr), .out_cached(out_cached), .out_fault(out_fault)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string seg_req(input logic [31:0] va, input logic erl);
      if (!va[31]) return erl ? "R5" : "R4";
      if (!va[30]) return "R2";
      return "R3";
   endfunction

   task automatic apply(input logic [31:0] va, input logic k, input logic erl);
      logic [31:0] ep;
      logic        ec;
      logic        ef;
      ef = !k && va[31];
      if (!va[31]) begin
         ep = erl ? va : va + 32'h4000_0000;
         ec = !erl;
      end else if (!va[30]) begin
         ep = va & 32'h1FFF_FFFF;
         ec = !va[29];
      end else begin
         ep = va;
         ec = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b1; in_vaddr = va; in_kernel = k; in_erl = erl;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 valid", {31'd0, out_valid}, 32'd1);
      chk("R7 fault", {31'd0, out_fault}, {31'd0, ef});
      if (!ef) begin
         chk({"R1/", seg_req(va, erl), " paddr"}, out_paddr, ep);
         chk({"R1/", seg_req(va, erl), " cached"}, {31'd0, out_cached}, {31'd0, ec});
         if (va[31]) begin
            checks++;
            if (out_paddr[31:30] == 2'b10) begin
               errors++;
               $display("FAIL R6 actual=%h expected=outside 80000000-BFFFFFFF", out_paddr);
            end
         end
      end
   endtask

   initial begin
      logic [31:0] held_p;
      logic        held_c;
      logic        held_f;
      logic [31:0] kp0;
      logic [31:0] kp1;
      logic        kc0;
      logic        kc1;
      repeat (3) @(negedge clk);
      // R9: reset state while reset is held
      chk("R9 valid", {31'd0, out_valid}, 32'd0);
      chk("R9 paddr", out_paddr, 32'd0);
      chk("R9 cached", {31'd0, out_cached}, 32'd0);
      chk("R9 fault", {31'd0, out_fault}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 valid after release", {31'd0, out_valid}, 32'd0);
      // R1..R7 sweep: first, middle and last address of each 512 MB slice
      for (int s = 0; s < 8; s++) begin
         for (int p = 0; p < 3; p++) begin
            for (int m = 0; m < 4; m++) begin
               logic [31:0] va;
               va = {s[2:0], 29'd0};
               if (p == 1) va = va | 29'h0ABC_1234;
               if (p == 2) va = va | 29'h1FFF_FFFF;
               apply(va, m[0], m[1]);
            end
         end
      end
      // R8: idle cycle holds data and drops valid
      apply(32'h8000_1000, 1'b1, 1'b0);
      held_p = out_paddr; held_c = out_cached; held_f = out_fault;
      in_vaddr = 32'h0000_0040; in_kernel = 1'b0; in_erl = 1'b1;
      @(negedge clk);
      chk("R8 idle valid", {31'd0, out_valid}, 32'd0);
      chk("R8 idle paddr", out_paddr, held_p);
      chk("R8 idle cached", {31'd0, out_cached}, {31'd0, held_c});
      chk("R8 idle fault", {31'd0, out_fault}, {31'd0, held_f});
      // R10: override flag ignored for high addresses
      for (int s = 4; s < 8; s++) begin
         logic [31:0] va;
         va = {s[2:0], 29'h0123_4560};
         apply(va, 1'b1, 1'b0);
         kp0 = out_paddr; kc0 = out_cached;
         apply(va, 1'b1, 1'b1);
         kp1 = out_paddr; kc1 = out_cached;
         chk("R10 paddr", kp1, kp0);
         chk("R10 cached", {31'd0, kc1}, {31'd0, kc0});
      end
      // R8: back-to-back requests
      @(negedge clk);
      in_valid = 1'b1; in_vaddr = 32'h0000_0100; in_kernel = 1'b1; in_erl = 1'b0;
      @(negedge clk);
      chk("R8 b2b first", out_paddr, 32'h4000_0100);
      in_vaddr = 32'hA000_0200;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 b2b second", out_paddr, 32'h0000_0200);
      chk("R8 b2b cached", {31'd0, out_cached}, 32'd0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule